// File: doc/BRIEF.md
# Byte-to-Word Block Transfer Engine

This engine sits between a byte-wide card data port and a 16-bit word buffer. It moves a block-structured transfer one byte at a time. When reading from the card it packs pairs of bytes into words and pushes them into the buffer. When writing to the card it takes words from the buffer head and sends them out as bytes. A block may hold an odd number of bytes. In that case the final word of each block carries only one byte.

Two configuration registers set the shape of a transfer: a block length in bytes and a number of blocks. Each is programmed as an 11-bit field that stands for the field value plus one. Two live counters track the bytes left in the current block and the blocks left in the transfer. Both counters are visible on the ports at all times. The host programs the registers, pulses `start` with a direction, and waits for `done`.

In the read direction the engine holds off the card while the buffer fill is above a programmable almost-full level. In the write direction it holds off while the buffer is empty.

Top module: `byte_word_xfer`

Engine states:
- `ST_IDLE`: no transfer is active.
- `ST_RD_LO`: waiting for the low byte of a word from the card.
- `ST_RD_HI`: waiting for the high byte of a word from the card.
- `ST_WR_LO`: sending the low byte of the buffer head.
- `ST_WR_HI`: sending the high byte of the buffer head.

Transitions:
- start: `ST_IDLE` to `ST_RD_LO` when `dir_rd`=1, or to `ST_WR_LO` when `dir_rd`=0.
- low byte taken, bytes remain: `ST_RD_LO` to `ST_RD_HI`, or `ST_WR_LO` to `ST_WR_HI`.
- word closed: `ST_RD_HI` to `ST_RD_LO`, or `ST_WR_HI` to `ST_WR_LO`.
- odd tail byte: a `*_LO` state stays where it is.
- finish: any active state goes to `ST_IDLE`.

## Requirements
- R1: A configuration write with `cfg_sel`=0 stores `cfg_wdata`+1 as the block length and loads the byte counter with that value. A write with `cfg_sel`=1 stores `cfg_wdata`+1 as the block number and loads the block counter with it.
- R2: A block-number write (`cfg_sel`=1) also reloads the byte counter from the stored block length.
- R3: When reading, the first byte of a word becomes bits 7:0 and the second byte becomes bits 15:8. If the first byte is the last byte of its block, the word is pushed alone with bits 15:8 equal to zero.
- R4: When writing, bits 7:0 of the buffer head are sent first. Bits 15:8 are sent only if the block still has bytes left. The head word is popped after its last sent byte. While a byte is offered and not accepted, the offered byte stays stable.
- R5: In `ST_RD_LO`, `card_rx_ready` stays low while `buf_level` > `af_level`.
- R6: In `ST_WR_LO`, `card_tx_valid` stays low while `buf_level` is 0.
- R7: When the byte counter passes its last byte and the block is not the last, the byte counter reloads from the block length and the block counter decrements by one.
- R8: After the last byte of the last block, both counters reload from the stored values, `busy` falls and `done` rises. `done` stays high until the next accepted `start`, which clears it.
- R9: `byte_cnt` and `blk_cnt` always show the live counters, including in the middle of a transfer.
- R10: While idle, nothing moves: `card_rx_ready`, `card_tx_valid`, `buf_push` and `buf_pop` are all low. While busy, configuration writes and `start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = block length, 1 = block number |
| cfg_wdata | input | 11 | Field value (stored as value+1) |
| start | input | 1 | Starts a transfer when idle |
| dir_rd | input | 1 | 1 = card to buffer, 0 = buffer to card |
| af_level | input | 5 | Buffer almost-full level |
| buf_level | input | 6 | Current buffer fill in words |
| busy | output | 1 | Transfer active |
| done | output | 1 | Sticky transfer-complete flag |
| byte_cnt | output | 12 | Live bytes left in the current block |
| blk_cnt | output | 12 | Live blocks left |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine takes the byte |
| card_tx_valid | output | 1 | Engine offers a byte |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card takes the byte |
| buf_push | output | 1 | Push a packed word |
| buf_push_data | output | 16 | Word to push |
| buf_head | input | 16 | Word at the buffer head |
| buf_pop | output | 1 | Pop the buffer head |

## Verification
Reads run with an odd block length over two blocks and are stopped after one byte and again after one block. This separates correct packing and tail-word zeroing from errors at block boundaries, and it exposes the live counter values. A second read uses an even length with an almost-full level of 1 while the bench drains one word. The number of bytes consumed shows whether the pause compares with greater-than or with greater-or-equal. Writes use an odd length over two blocks with the buffer part-filled, so the empty-buffer pause, the skipped high byte and the pop timing all show in the captured byte order. A slow card-side ready checks the hold behaviour. Writes while busy and card activity while idle confirm that both are ignored.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_LO = 3'd1,
        ST_RD_HI = 3'd2,
        ST_WR_LO = 3'd3,
        ST_WR_HI = 3'd4
    } xfer_state_e;

    localparam logic CFG_SEL_LEN = 1'b0;
    localparam logic CFG_SEL_NUM = 1'b1;

endpackage

// File: rtl/bwx_counters.sv
module bwx_counters #(
    parameter int FIELD_W = 11,
    localparam int CNT_W  = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [FIELD_W-1:0] cfg_wdata,
    input  logic               busy,
    input  logic               step,
    output logic               last_byte,
    output logic               last_blk,
    output logic [CNT_W-1:0]   byte_cnt,
    output logic [CNT_W-1:0]   blk_cnt
);
    import bwx_pkg::*;

    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] num_q;
    logic [CNT_W-1:0] field_p1;

    assign field_p1  = {1'b0, cfg_wdata} + CNT_W'(1);
    assign last_byte = (byte_cnt == CNT_W'(1));
    assign last_blk  = (blk_cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= CNT_W'(1);
            num_q    <= CNT_W'(1);
            byte_cnt <= CNT_W'(1);
            blk_cnt  <= CNT_W'(1);
        end else if (cfg_wr && !busy) begin
            if (cfg_sel == CFG_SEL_LEN) begin
                len_q    <= field_p1;
                byte_cnt <= field_p1;
            end else begin
                num_q    <= field_p1;
                blk_cnt  <= field_p1;
                byte_cnt <= len_q;
            end
        end else if (step) begin
            if (last_byte) begin
                byte_cnt <= len_q;
                if (last_blk) begin
                    blk_cnt <= num_q;
                end else begin
                    blk_cnt <= blk_cnt - CNT_W'(1);
                end
            end else begin
                byte_cnt <= byte_cnt - CNT_W'(1);
            end
        end
    end

    // R1
    cfg_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !busy && cfg_sel == CFG_SEL_LEN) |=>
            byte_cnt == {1'b0, $past(cfg_wdata)} + CNT_W'(1));

    // R2
    cfg_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !busy && cfg_sel == CFG_SEL_NUM) |=>
            (blk_cnt == {1'b0, $past(cfg_wdata)} + CNT_W'(1)) && (byte_cnt == len_q));

    // R7
    blk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(cfg_wr && !busy) && last_byte && !last_blk) |=>
            (blk_cnt == $past(blk_cnt) - CNT_W'(1)) && (byte_cnt == len_q));

    // R8
    final_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(cfg_wr && !busy) && last_byte && last_blk) |=>
            (blk_cnt == num_q) && (byte_cnt == len_q));

    // R9
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt != '0) && (blk_cnt != '0));

endmodule

// File: rtl/bwx_fsm.sv
module bwx_fsm #(
    parameter int LVL_W = 6,
    parameter int AF_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_rd,
    input  logic [AF_W-1:0]  af_level,
    input  logic [LVL_W-1:0] buf_level,
    input  logic             last_byte,
    input  logic             last_blk,
    output logic             step,
    output logic             busy,
    output logic             done,
    input  logic             card_rx_valid,
    input  logic [7:0]       card_rx_data,
    output logic             card_rx_ready,
    output logic             card_tx_valid,
    output logic [7:0]       card_tx_data,
    input  logic             card_tx_ready,
    output logic             buf_push,
    output logic [15:0]      buf_push_data,
    input  logic [15:0]      buf_head,
    output logic             buf_pop
);
    import bwx_pkg::*;

    xfer_state_e state_q, state_d;
    logic [7:0]  lo_q;
    logic        done_q;
    logic        rx_fire, tx_fire, finish, go, above_af;

    assign above_af = ({{(LVL_W > AF_W ? 0 : 1){1'b0}}, buf_level} >
                       {{(LVL_W - AF_W){1'b0}}, af_level});
    assign go       = start && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lo_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rx_fire && state_q == ST_RD_LO) begin
                lo_q <= card_rx_data;
            end
            if (go) begin
                done_q <= 1'b0;
            end else if (finish) begin
                done_q <= 1'b1;
            end
        end
    end

    // outputs and next state
    always_comb begin
        state_d       = state_q;
        card_rx_ready = 1'b0;
        card_tx_valid = 1'b0;
        card_tx_data  = 8'h00;
        buf_push      = 1'b0;
        buf_push_data = 16'h0000;
        buf_pop       = 1'b0;
        rx_fire       = 1'b0;
        tx_fire       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = dir_rd ? ST_RD_LO : ST_WR_LO;
                end
            end
            ST_RD_LO: begin
                card_rx_ready = !above_af;
                rx_fire       = card_rx_valid && card_rx_ready;
                if (rx_fire) begin
                    if (last_byte) begin
                        buf_push      = 1'b1;
                        buf_push_data = {8'h00, card_rx_data};
                        state_d       = last_blk ? ST_IDLE : ST_RD_LO;
                    end else begin
                        state_d = ST_RD_HI;
                    end
                end
            end
            ST_RD_HI: begin
                card_rx_ready = 1'b1;
                rx_fire       = card_rx_valid;
                if (rx_fire) begin
                    buf_push      = 1'b1;
                    buf_push_data = {card_rx_data, lo_q};
                    state_d       = (last_byte && last_blk) ? ST_IDLE : ST_RD_LO;
                end
            end
            ST_WR_LO: begin
                card_tx_valid = (buf_level != '0);
                card_tx_data  = buf_head[7:0];
                tx_fire       = card_tx_valid && card_tx_ready;
                if (tx_fire) begin
                    if (last_byte) begin
                        buf_pop = 1'b1;
                        state_d = last_blk ? ST_IDLE : ST_WR_LO;
                    end else begin
                        state_d = ST_WR_HI;
                    end
                end
            end
            ST_WR_HI: begin
                card_tx_valid = 1'b1;
                card_tx_data  = buf_head[15:8];
                tx_fire       = card_tx_ready;
                if (tx_fire) begin
                    buf_pop = 1'b1;
                    state_d = (last_byte && last_blk) ? ST_IDLE : ST_WR_LO;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign step   = rx_fire || tx_fire;
    assign finish = step && last_byte && last_blk;
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !card_rx_ready && !card_tx_valid && !buf_push && !buf_pop);

    // R5
    rd_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_LO && above_af) |-> !card_rx_ready);

    // R6
    wr_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_LO && buf_level == '0) |-> !card_tx_valid);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_tx_valid && !card_tx_ready) |=> card_tx_valid && $stable(card_tx_data));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

    // R3
    one_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_push && buf_pop));

endmodule

// File: rtl/byte_word_xfer.sv
module byte_word_xfer #(
    parameter int FIELD_W = 11,
    parameter int LVL_W   = 6,
    parameter int AF_W    = 5,
    localparam int CNT_W  = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [FIELD_W-1:0] cfg_wdata,
    input  logic               start,
    input  logic               dir_rd,
    input  logic [AF_W-1:0]    af_level,
    input  logic [LVL_W-1:0]   buf_level,
    output logic               busy,
    output logic               done,
    output logic [CNT_W-1:0]   byte_cnt,
    output logic [CNT_W-1:0]   blk_cnt,
    input  logic               card_rx_valid,
    input  logic [7:0]         card_rx_data,
    output logic               card_rx_ready,
    output logic               card_tx_valid,
    output logic [7:0]         card_tx_data,
    input  logic               card_tx_ready,
    output logic               buf_push,
    output logic [15:0]        buf_push_data,
    input  logic [15:0]        buf_head,
    output logic               buf_pop
);
    logic step, last_byte, last_blk;

    bwx_counters #(.FIELD_W(FIELD_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .step      (step),
        .last_byte (last_byte),
        .last_blk  (last_blk),
        .byte_cnt  (byte_cnt),
        .blk_cnt   (blk_cnt)
    );

    bwx_fsm #(.LVL_W(LVL_W), .AF_W(AF_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .dir_rd        (dir_rd),
        .af_level      (af_level),
        .buf_level     (buf_level),
        .last_byte     (last_byte),
        .last_blk      (last_blk),
        .step          (step),
        .busy          (busy),
        .done          (done),
        .card_rx_valid (card_rx_valid),
        .card_rx_data  (card_rx_data),
        .card_rx_ready (card_rx_ready),
        .card_tx_valid (card_tx_valid),
        .card_tx_data  (card_tx_data),
        .card_tx_ready (card_tx_ready),
        .buf_push      (buf_push),
        .buf_push_data (buf_push_data),
        .buf_head      (buf_head),
        .buf_pop       (buf_pop)
    );

    // R10
    no_cfg_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> $stable(blk_cnt) || $past(step));

endmodule

// File: tb/byte_word_xfer_tb.sv
module byte_word_xfer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0, start = 1'b0, dir_rd = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic [4:0]  af_level = 5'd31;
    logic [5:0]  buf_level;
    logic        busy, done;
    logic [11:0] byte_cnt, blk_cnt;
    logic        rx_valid, rx_ready, tx_valid, tx_ready;
    logic [7:0]  rx_data, tx_data;
    logic        push, pop;
    logic [15:0] push_data, head;

    // bench models
    logic [15:0] bmem [0:63];
    logic [5:0]  bwp, brp;
    int          rx_idx, rx_total, tx_n, cyc;
    logic [7:0]  tx_log [0:63];
    logic        tb_clr = 1'b0, tb_fill = 1'b0, tb_pop = 1'b0;
    logic [15:0] tb_fill_data = '0;
    logic        rx_slow = 1'b0, tx_on = 1'b0, tx_slow = 1'b0;
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rx_byte(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    assign buf_level = bwp - brp;
    assign head      = bmem[brp];
    assign rx_valid  = (rx_idx < rx_total) && (!rx_slow || cyc[0]);
    assign rx_data   = rx_byte(rx_idx);
    assign tx_ready  = tx_on && (!tx_slow || cyc[1]);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tb_clr) begin
            bwp <= '0; brp <= '0; rx_idx <= 0; tx_n <= 0;
        end else begin
            if (push) bmem[bwp] <= push_data;
            if (tb_fill) bmem[bwp] <= tb_fill_data;
            if (push || tb_fill) bwp <= bwp + 6'd1;
            if (pop || tb_pop) brp <= brp + 6'd1;
            if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
            if (tx_valid && tx_ready) begin
                tx_log[tx_n[5:0]] <= tx_data;
                tx_n <= tx_n + 1;
            end
        end
    end

    byte_word_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .dir_rd(dir_rd),
        .af_level(af_level), .buf_level(buf_level), .busy(busy), .done(done),
        .byte_cnt(byte_cnt), .blk_cnt(blk_cnt),
        .card_rx_valid(rx_valid), .card_rx_data(rx_data), .card_rx_ready(rx_ready),
        .card_tx_valid(tx_valid), .card_tx_data(tx_data), .card_tx_ready(tx_ready),
        .buf_push(push), .buf_push_data(push_data), .buf_head(head), .buf_pop(pop)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(logic sel, int v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = 11'(v);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic go(logic rd);
        @(negedge clk);
        start = 1'b1; dir_rd = rd;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic clr_models();
        @(negedge clk); tb_clr = 1'b1;
        @(negedge clk); tb_clr = 1'b0;
        rx_total = 0;
    endtask

    task automatic fill(logic [15:0] w);
        @(negedge clk); tb_fill = 1'b1; tb_fill_data = w;
        @(negedge clk); tb_fill = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 busy after reset", busy, 0);
        chk("R8 done after reset", done, 0);
        chk("R9 byte_cnt after reset", byte_cnt, 1);
        chk("R9 blk_cnt after reset", blk_cnt, 1);
        chk("R10 rx_ready idle", rx_ready, 0);
        chk("R10 tx_valid idle", tx_valid, 0);
    endtask

    task automatic t_config();
        cfg(1'b0, 4);
        chk("R1 length write", byte_cnt, 5);
        cfg(1'b1, 1);
        chk("R1 number write", blk_cnt, 2);
        chk("R2 byte reload on number write", byte_cnt, 5);
        cfg(1'b0, 2);
        chk("R1 length rewrite", byte_cnt, 3);
        cfg(1'b1, 1);
        chk("R2 reload from new length", byte_cnt, 3);
    endtask

    task automatic t_read_odd();
        clr_models();
        af_level = 5'd31; rx_slow = 1'b1;
        go(1'b1);
        chk("R8 done clear after start", done, 0);
        rx_total = 1; idle(10);
        chk("R9 live byte_cnt mid word", byte_cnt, 2);
        chk("R9 live blk_cnt mid word", blk_cnt, 2);
        rx_total = 3; idle(12);
        chk("R7 byte reload at block end", byte_cnt, 3);
        chk("R7 block decrement", blk_cnt, 1);
        chk("R3 two words after block", buf_level, 2);
        rx_total = 6; wait_idle(); idle(2);
        chk("R3 word0", bmem[0], {rx_byte(1), rx_byte(0)});
        chk("R3 word1 odd tail", bmem[1], {8'h00, rx_byte(2)});
        chk("R3 word2", bmem[2], {rx_byte(4), rx_byte(3)});
        chk("R3 word3 odd tail", bmem[3], {8'h00, rx_byte(5)});
        chk("R8 busy falls", busy, 0);
        chk("R8 done set", done, 1);
        chk("R8 byte_cnt reloaded", byte_cnt, 3);
        chk("R8 blk_cnt reloaded", blk_cnt, 2);
        rx_total = 8; idle(10);
        chk("R10 idle takes no bytes", rx_idx, 6);
        chk("R10 idle pushes nothing", buf_level, 4);
        rx_slow = 1'b0;
    endtask

    task automatic t_read_pause();
        clr_models();
        cfg(1'b0, 7); cfg(1'b1, 0);
        af_level = 5'd1;
        go(1'b1);
        rx_total = 8; idle(20);
        chk("R5 paused fill", buf_level, 2);
        chk("R5 bytes taken", rx_idx, 4);
        chk("R5 ready low in pause", rx_ready, 0);
        chk("R9 live count in pause", byte_cnt, 4);
        @(negedge clk); tb_pop = 1'b1;
        @(negedge clk); tb_pop = 1'b0;
        idle(10);
        chk("R5 resume one word", rx_idx, 6);
        af_level = 5'd31;
        wait_idle(); idle(2);
        chk("R5 all bytes", rx_idx, 8);
        chk("R3 even last word", bmem[3], {rx_byte(7), rx_byte(6)});
        chk("R8 done after even read", done, 1);
    endtask

    task automatic t_write();
        logic [7:0] exp [0:9];
        exp = '{8'hA1, 8'hB1, 8'hA2, 8'hB2, 8'hA3, 8'hA4, 8'hB4, 8'hA5, 8'hB5, 8'hA6};
        clr_models();
        cfg(1'b0, 4); cfg(1'b1, 1);
        fill(16'hB1A1); fill(16'hB2A2);
        tx_on = 1'b1; tx_slow = 1'b0;
        go(1'b0);
        idle(20);
        chk("R6 bytes before empty", tx_n, 4);
        chk("R6 valid low when empty", tx_valid, 0);
        chk("R6 still busy", busy, 1);
        chk("R9 byte_cnt in pause", byte_cnt, 1);
        cfg(1'b0, 9);
        chk("R10 length write ignored busy", byte_cnt, 1);
        go(1'b1);
        tx_slow = 1'b1;
        fill(16'hFFA3); fill(16'hB4A4); fill(16'hB5A5); fill(16'hEEA6);
        wait_idle(); idle(2);
        chk("R4 byte count", tx_n, 10);
        for (int i = 0; i < 10; i++) chk("R4 byte order", tx_log[i], exp[i]);
        chk("R4 all words popped", buf_level, 0);
        chk("R8 write done", done, 1);
        chk("R10 length unchanged", byte_cnt, 5);
        chk("R8 blk reload after write", blk_cnt, 2);
        tx_on = 1'b0;
    endtask

    task automatic t_restart();
        clr_models();
        go(1'b1);
        chk("R8 done cleared by start", done, 0);
        chk("R8 busy after start", busy, 1);
    endtask

    always @(posedge clk) begin
        if (cyc > WD_LIMIT && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc = 0; rx_total = 0;
        bwp = '0; brp = '0; rx_idx = 0; tx_n = 0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_config();
        t_read_odd();
        t_read_pause();
        t_write();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule